// File: doc/BRIEF.md
# AXI address segmentation remapper

This block sits on the read and write address channels between a processor complex and a DRAM controller. For every request it checks whether the address falls inside one of up to seven processor windows. On a hit it adds that window's signed offset to address bits [37:24], so that the window lands on a chosen DRAM base. Addresses that hit no window leave unchanged. The rewrite is combinational, so the address channels gain no cycles. Write data, write response and read data channels do not pass through this block; they run beside it unchanged.

An APB slave exposes eight 32-bit configuration words. Each live word can be frozen by its own lock bit until reset. One word carries a sticky enable that keeps every address transfer stalled until software sets it. A parameter picks between two instance kinds. Each kind owns a different subset of the eight words and treats the others as reserved.

Top module: `axi_seg_remap`

## Requirements
- R1: Word k (0 to 7) sits at APB byte offset 4*k and is selected by address bits [4:2]. An offset word reads back as lock in bit 31 and the offset in bits [14:0]. The control word reads back as lock in bit 31 and the enable in bit 0.
- R2: Once a write sets bit 31 of a word, later writes to that word change nothing until reset. The write that sets the lock also stores its other fields. Reset clears the lock.
- R3: Bits [30:15] of offset words, and bits [30:1] of the control word, always read as zero whatever was written.
- R4: On a hit in window w, output bits [37:24] equal input bits [37:24] plus offset bits [13:0], modulo 2^14, so a negative 15-bit offset moves the address down and any carry out of bit 37 is lost. Bits [23:0] are never changed.
- R5: There are seven windows. Windows 0, 2, 4 and 6 are 256 MB at 0x00_8000_0000, 0x00_C000_0000, 0x00_D000_0000 and 0x00_E000_0000. Windows 1, 3 and 5 are 16 GB at 0x10_0000_0000, 0x14_0000_0000 and 0x18_0000_0000. Window 6 serves trace traffic.
- R6: An address that hits no live window leaves the block unchanged.
- R7: With KIND=0, words 0, 1 and 7 are live. With KIND=1, words 2 to 6 are live. A window whose word is reserved never translates.
- R8: A reserved word reads as zero, and writes to it are ignored and still complete normally.
- R9: The enable (word 7, bit 0) is zero after reset. With KIND=0 and the enable at zero, s_awready, s_arready, m_awvalid and m_arvalid are all low. Writing 1 sets the enable, and writing 0 does not clear it. With KIND=1 the block never stalls.
- R10: While the block is open, valid passes downstream and ready passes upstream in the same cycle, and the translated address is on m_*addr in the cycle the request is presented.
- R11: apb_ready is always 1 and apb_err always 0. A write takes effect on the clock edge that ends its access phase, so an address transfer in that same cycle still uses the old value.
- R12: Reset puts every word at zero, which clears every lock, every offset and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| apb_sel | input | 1 | APB select |
| apb_enable | input | 1 | APB access phase |
| apb_write | input | 1 | APB write when high |
| apb_addr | input | 3 | APB byte address bits [4:2] (word index) |
| apb_wdata | input | 32 | APB write data |
| apb_rdata | output | 32 | APB read data of the indexed word |
| apb_ready | output | 1 | APB ready, tied high |
| apb_err | output | 1 | APB error, tied low |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awaddr | input | 38 | Upstream write address |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Downstream write address ready |
| m_awaddr | output | 38 | Translated write address |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_araddr | input | 38 | Upstream read address |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Downstream read address ready |
| m_araddr | output | 38 | Translated read address |

## Verification
Two operations can meet in one cycle: an APB write that changes a window's offset or the enable, and an address transfer that depends on that same value. The bench provokes this by holding a read request inside window 2 while the access phase of a write to word 2 is in progress. It expects the old translation in that cycle and the new one in the next. The same clash arises in random phases, where bus traffic runs during register writes and a model updated on each edge is compared with both instance kinds on every clock.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W     = 38;
  localparam int XLATE_LSB  = 24;
  localparam int HI_W       = ADDR_W - XLATE_LSB;
  localparam int OFF_W      = 15;
  localparam int NREG       = 8;
  localparam int NWIN       = NREG - 1;
  localparam int IDX_W      = $clog2(NREG);
  localparam int CTL_IDX    = NREG - 1;
  localparam int LOCK_BIT   = 31;
  localparam int UNB_BIT    = 0;
  localparam int LO_LOG2    = 28;
  localparam int HI_LOG2    = 34;
  localparam int KIND_CACHED   = 0;
  localparam int KIND_UNCACHED = 1;

  function automatic logic [ADDR_W-1:0] win_base(input int idx);
    case (idx)
      0:       return 38'h00_8000_0000;
      1:       return 38'h10_0000_0000;
      2:       return 38'h00_C000_0000;
      3:       return 38'h14_0000_0000;
      4:       return 38'h00_D000_0000;
      5:       return 38'h18_0000_0000;
      default: return 38'h00_E000_0000;
    endcase
  endfunction

  function automatic int win_log2(input int idx);
    return (idx == 1 || idx == 3 || idx == 5) ? HI_LOG2 : LO_LOG2;
  endfunction

  function automatic logic reg_live(input int kind, input int idx);
    if (kind == KIND_CACHED) return (idx == 0) || (idx == 1) || (idx == CTL_IDX);
    return (idx >= 2) && (idx <= 6);
  endfunction
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
  import seg_pkg::*;
#(
  parameter int KIND = KIND_CACHED
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       apb_sel,
  input  logic                       apb_enable,
  input  logic                       apb_write,
  input  logic [IDX_W-1:0]           apb_idx,
  input  logic [31:0]                apb_wdata,
  output logic [31:0]                apb_rdata,
  output logic [NREG-1:0]            lock_o,
  output logic [NWIN-1:0][OFF_W-1:0] off_o,
  output logic                       unblock_o
);
  logic                  wr_acc;
  logic [NREG-1:0][31:0] rd_word;
  logic                  unused_wd;

  assign wr_acc    = apb_sel & apb_enable & apb_write;
  assign unused_wd = ^apb_wdata[LOCK_BIT-1:OFF_W];

  for (genvar i = 0; i < NREG; i++) begin : g_word
    if (reg_live(KIND, i)) begin : g_live
      logic wr_en;
      logic lock_q, lock_d;

      assign wr_en  = wr_acc && (apb_idx == IDX_W'(i)) && !lock_q;
      assign lock_d = apb_wdata[LOCK_BIT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lock_q <= 1'b0;
        else if (wr_en) lock_q <= lock_d;
      end
      assign lock_o[i] = lock_q;

      if (i < NWIN) begin : g_off
        logic [OFF_W-1:0] off_q, off_d;
        always_comb off_d = apb_wdata[OFF_W-1:0];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     off_q <= '0;
          else if (wr_en) off_q <= off_d;
        end
        assign off_o[i]   = off_q;
        assign rd_word[i] = {lock_q, {(31-OFF_W){1'b0}}, off_q};
      end else begin : g_ctl
        logic unb_q, unb_d;
        always_comb unb_d = unb_q | apb_wdata[UNB_BIT];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     unb_q <= 1'b0;
          else if (wr_en) unb_q <= unb_d;
        end
        assign unblock_o  = unb_q;
        assign rd_word[i] = {lock_q, 30'b0, unb_q};
      end
    end else begin : g_rsvd
      assign lock_o[i]  = 1'b0;
      assign rd_word[i] = 32'h0;
      if (i < NWIN) begin : g_off0
        assign off_o[i] = '0;
      end else begin : g_ctl0
        assign unblock_o = 1'b0;
      end
    end
  end

  assign apb_rdata = rd_word[apb_idx];
endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate
  import seg_pkg::*;
#(
  parameter int KIND = KIND_CACHED
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NWIN-1:0][HI_W-1:0] off_i,
  output logic [ADDR_W-1:0]         addr_o
);
  logic [NWIN-1:0] hit;
  logic [HI_W-1:0] sel_off;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    if (reg_live(KIND, i)) begin : g_on
      localparam int               LG   = win_log2(i);
      localparam logic [ADDR_W-1:0] BASE = win_base(i);
      assign hit[i] = (addr_i >> LG) == (BASE >> LG);
    end else begin : g_off
      logic unused_win;
      assign unused_win = ^off_i[i];
      assign hit[i]     = 1'b0;
    end
  end

  always_comb begin
    sel_off = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) sel_off = off_i[i];
    end
  end

  assign addr_o = {addr_i[ADDR_W-1:XLATE_LSB] + sel_off, addr_i[XLATE_LSB-1:0]};
endmodule

// File: rtl/seg_axi_gate.sv
module seg_axi_gate (
  input  logic open_i,
  input  logic s_valid_i,
  output logic s_ready_o,
  output logic m_valid_o,
  input  logic m_ready_i
);
  assign m_valid_o = s_valid_i & open_i;
  assign s_ready_o = m_ready_i & open_i;
endmodule

// File: rtl/axi_seg_remap.sv
module axi_seg_remap
  import seg_pkg::*;
#(
  parameter int KIND = KIND_CACHED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apb_sel,
  input  logic              apb_enable,
  input  logic              apb_write,
  input  logic [IDX_W+1:2]  apb_addr,
  input  logic [31:0]       apb_wdata,
  output logic [31:0]       apb_rdata,
  output logic              apb_ready,
  output logic              apb_err,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr
);
  logic [1:0]                rst_pipe;
  logic                      rst_sync;
  logic [NREG-1:0]           lock_q;
  logic [NWIN-1:0][OFF_W-1:0] off_q;
  logic [NWIN-1:0][HI_W-1:0]  xl_off;
  logic                      unblock;
  logic                      gate_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  assign apb_ready = 1'b1;
  assign apb_err   = 1'b0;

  seg_cfg_regs #(.KIND(KIND)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .apb_sel   (apb_sel),
    .apb_enable(apb_enable),
    .apb_write (apb_write),
    .apb_idx   (apb_addr),
    .apb_wdata (apb_wdata),
    .apb_rdata (apb_rdata),
    .lock_o    (lock_q),
    .off_o     (off_q),
    .unblock_o (unblock)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_trim
    assign xl_off[i] = off_q[i][HI_W-1:0];
  end

  if (KIND == KIND_CACHED) begin : g_gated
    assign gate_open = unblock;
  end else begin : g_free
    assign gate_open = 1'b1;
  end

  seg_addr_xlate #(.KIND(KIND)) u_xlate_aw (
    .addr_i(s_awaddr),
    .off_i (xl_off),
    .addr_o(m_awaddr)
  );

  seg_addr_xlate #(.KIND(KIND)) u_xlate_ar (
    .addr_i(s_araddr),
    .off_i (xl_off),
    .addr_o(m_araddr)
  );

  seg_axi_gate u_gate_aw (
    .open_i   (gate_open),
    .s_valid_i(s_awvalid),
    .s_ready_o(s_awready),
    .m_valid_o(m_awvalid),
    .m_ready_i(m_awready)
  );

  seg_axi_gate u_gate_ar (
    .open_i   (gate_open),
    .s_valid_i(s_arvalid),
    .s_ready_o(s_arready),
    .m_valid_o(m_arvalid),
    .m_ready_i(m_arready)
  );
endmodule

// File: rtl/seg_remap_chk.sv
module seg_remap_chk
  import seg_pkg::*;
#(
  parameter int KIND = KIND_CACHED
) (
  input logic                       clk,
  input logic                       rst_sync,
  input logic                       gate_open,
  input logic                       unblock,
  input logic [NREG-1:0]            lock_q,
  input logic [NWIN-1:0][OFF_W-1:0] off_q,
  input logic                       apb_sel,
  input logic [IDX_W+1:2]           apb_addr,
  input logic [31:0]                apb_rdata,
  input logic                       apb_ready,
  input logic                       apb_err,
  input logic                       s_awvalid,
  input logic                       s_awready,
  input logic [ADDR_W-1:0]          s_awaddr,
  input logic                       m_awvalid,
  input logic                       m_awready,
  input logic [ADDR_W-1:0]          m_awaddr,
  input logic                       s_arvalid,
  input logic                       s_arready,
  input logic [ADDR_W-1:0]          s_araddr,
  input logic                       m_arvalid,
  input logic                       m_arready,
  input logic [ADDR_W-1:0]          m_araddr
);
  assert_gate_shut_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    !gate_open |-> (!m_awvalid && !m_arvalid && !s_awready && !s_arready));

  assert_unblock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    unblock |=> unblock);

  assert_low_bits_kept_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    (m_awaddr[XLATE_LSB-1:0] == s_awaddr[XLATE_LSB-1:0]) &&
    (m_araddr[XLATE_LSB-1:0] == s_araddr[XLATE_LSB-1:0]));

  assert_handshake_pass_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    gate_open |-> (m_awvalid == s_awvalid && s_awready == m_awready &&
                   m_arvalid == s_arvalid && s_arready == m_arready));

  assert_apb_resp_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    apb_ready && !apb_err);

  assert_reserved_read_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (apb_sel && !reg_live(KIND, int'(apb_addr))) |-> (apb_rdata == 32'h0));

  assert_reserved_bits_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    apb_rdata[30:OFF_W] == '0);

  for (genvar i = 0; i < NWIN; i++) begin : g_lock
    assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync)
      lock_q[i] |=> (lock_q[i] && $stable(off_q[i])));
  end

  assert_ctl_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    lock_q[CTL_IDX] |=> (lock_q[CTL_IDX] && $stable(unblock)));
endmodule

bind axi_seg_remap seg_remap_chk #(.KIND(KIND)) u_seg_remap_chk (
  .clk      (clk),
  .rst_sync (rst_sync),
  .gate_open(gate_open),
  .unblock  (unblock),
  .lock_q   (lock_q),
  .off_q    (off_q),
  .apb_sel  (apb_sel),
  .apb_addr (apb_addr),
  .apb_rdata(apb_rdata),
  .apb_ready(apb_ready),
  .apb_err  (apb_err),
  .s_awvalid(s_awvalid),
  .s_awready(s_awready),
  .s_awaddr (s_awaddr),
  .m_awvalid(m_awvalid),
  .m_awready(m_awready),
  .m_awaddr (m_awaddr),
  .s_arvalid(s_arvalid),
  .s_arready(s_arready),
  .s_araddr (s_araddr),
  .m_arvalid(m_arvalid),
  .m_arready(m_arready),
  .m_araddr (m_araddr)
);

// File: tb/test_axi_seg_remap.sv
module test_axi_seg_remap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        apb_sel, apb_enable, apb_write;
  logic [4:2]  apb_addr;
  logic [31:0] apb_wdata;
  logic        s_awvalid, m_awready, s_arvalid, m_arready;
  logic [37:0] s_awaddr, s_araddr;

  logic [31:0] rdata_o   [2];
  logic        ready_o   [2];
  logic        err_o     [2];
  logic        s_awready_o [2];
  logic        m_awvalid_o [2];
  logic [37:0] m_awaddr_o  [2];
  logic        s_arready_o [2];
  logic        m_arvalid_o [2];
  logic [37:0] m_araddr_o  [2];

  int  n_chk = 0;
  int  n_bad = 0;
  bit  cmp_en = 0;
  bit  done = 0;

  logic [14:0] moff  [2][8];
  bit          mlock [2][8];
  bit          munb  [2];

  always #2 clk = ~clk;

  axi_seg_remap #(.KIND(0)) i_axi_seg_remap (
    .clk(clk), .rst_n(rst_n),
    .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
    .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(rdata_o[0]),
    .apb_ready(ready_o[0]), .apb_err(err_o[0]),
    .s_awvalid(s_awvalid), .s_awready(s_awready_o[0]), .s_awaddr(s_awaddr),
    .m_awvalid(m_awvalid_o[0]), .m_awready(m_awready), .m_awaddr(m_awaddr_o[0]),
    .s_arvalid(s_arvalid), .s_arready(s_arready_o[0]), .s_araddr(s_araddr),
    .m_arvalid(m_arvalid_o[0]), .m_arready(m_arready), .m_araddr(m_araddr_o[0])
  );

  axi_seg_remap #(.KIND(1)) i_axi_seg_remap_k1 (
    .clk(clk), .rst_n(rst_n),
    .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
    .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(rdata_o[1]),
    .apb_ready(ready_o[1]), .apb_err(err_o[1]),
    .s_awvalid(s_awvalid), .s_awready(s_awready_o[1]), .s_awaddr(s_awaddr),
    .m_awvalid(m_awvalid_o[1]), .m_awready(m_awready), .m_awaddr(m_awaddr_o[1]),
    .s_arvalid(s_arvalid), .s_arready(s_arready_o[1]), .s_araddr(s_araddr),
    .m_arvalid(m_arvalid_o[1]), .m_arready(m_arready), .m_araddr(m_araddr_o[1])
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Word map per kind (R7): kind 0 owns 0,1,7; kind 1 owns 2..6
  function automatic bit live(input int k, input int i);
    if (k == 0) return (i < 2) || (i == 7);
    return (i >= 2) && (i <= 6);
  endfunction

  function automatic logic [63:0] wbase(input int i);
    case (i)
      0: return 64'h00_8000_0000;
      1: return 64'h10_0000_0000;
      2: return 64'h00_C000_0000;
      3: return 64'h14_0000_0000;
      4: return 64'h00_D000_0000;
      5: return 64'h18_0000_0000;
      default: return 64'h00_E000_0000;
    endcase
  endfunction

  function automatic logic [63:0] wsize(input int i);
    return (i == 1 || i == 3 || i == 5) ? 64'h4_0000_0000 : 64'h1000_0000;
  endfunction

  function automatic logic [37:0] ref_addr(input int k, input logic [37:0] a);
    logic [63:0] ua;
    logic [13:0] hi;
    ua = {26'b0, a};
    for (int i = 0; i < 7; i++) begin
      if (live(k, i) && ua >= wbase(i) && ua < wbase(i) + wsize(i)) begin
        hi = a[37:24] + moff[k][i][13:0];
        return {hi, a[23:0]};
      end
    end
    return a;
  endfunction

  // Behavioural model of the word bank, updated at each edge
  always @(posedge clk or negedge rst_n) begin
    int ix;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        munb[k] = 0;
        for (int i = 0; i < 8; i++) begin
          moff[k][i]  = '0;
          mlock[k][i] = 0;
        end
      end
    end else if (apb_sel && apb_enable && apb_write) begin
      ix = int'(apb_addr);
      for (int k = 0; k < 2; k++) begin
        if (live(k, ix) && !mlock[k][ix]) begin
          mlock[k][ix] = apb_wdata[31];
          if (ix == 7) begin
            if (apb_wdata[0]) munb[k] = 1;
          end else begin
            moff[k][ix] = apb_wdata[14:0];
          end
        end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    bit op;
    if (cmp_en && !done) begin
      for (int k = 0; k < 2; k++) begin
        op = (k == 0) ? munb[0] : 1'b1;
        chk("R4 m_awaddr", {26'b0, m_awaddr_o[k]}, {26'b0, ref_addr(k, s_awaddr)});
        chk("R4 m_araddr", {26'b0, m_araddr_o[k]}, {26'b0, ref_addr(k, s_araddr)});
        chk("R9 R10 m_awvalid", {63'b0, m_awvalid_o[k]}, {63'b0, s_awvalid & op});
        chk("R9 R10 s_awready", {63'b0, s_awready_o[k]}, {63'b0, m_awready & op});
        chk("R9 R10 m_arvalid", {63'b0, m_arvalid_o[k]}, {63'b0, s_arvalid & op});
        chk("R9 R10 s_arready", {63'b0, s_arready_o[k]}, {63'b0, m_arready & op});
        chk("R11 apb resp", {62'b0, ready_o[k], err_o[k]}, 64'h2);
      end
    end
  end

  task automatic apb_wr(input int off, input logic [31:0] d);
    @(posedge clk); #1;
    apb_sel = 1; apb_enable = 0; apb_write = 1; apb_addr = off[4:2]; apb_wdata = d;
    @(posedge clk); #1;
    apb_enable = 1;
    @(posedge clk); #1;
    apb_sel = 0; apb_enable = 0; apb_write = 0;
  endtask

  task automatic apb_rd(input string tag, input int off, input logic [31:0] e0, input logic [31:0] e1);
    @(posedge clk); #1;
    apb_sel = 1; apb_enable = 0; apb_write = 0; apb_addr = off[4:2];
    @(posedge clk); #1;
    apb_enable = 1;
    @(negedge clk);
    chk(tag, {32'b0, rdata_o[0]}, {32'b0, e0});
    chk(tag, {32'b0, rdata_o[1]}, {32'b0, e1});
    @(posedge clk); #1;
    apb_sel = 0; apb_enable = 0;
  endtask

  task automatic addr_chk(input string tag, input logic [37:0] a, input logic [37:0] e0, input logic [37:0] e1);
    @(posedge clk); #1;
    s_araddr = a; s_arvalid = 1; s_awaddr = a; s_awvalid = 1;
    @(negedge clk);
    chk(tag, {26'b0, m_araddr_o[0]}, {26'b0, e0});
    chk(tag, {26'b0, m_araddr_o[1]}, {26'b0, e1});
    chk(tag, {26'b0, m_awaddr_o[1]}, {26'b0, e1});
  endtask

  function automatic logic [37:0] pick();
    int r, w;
    logic [63:0] v;
    r = $urandom_range(0, 9);
    if (r < 7) v = wbase(r) + ({$urandom, $urandom} % wsize(r));
    else if (r == 7) begin w = $urandom_range(0, 6); v = wbase(w) + wsize(w) - 1; end
    else if (r == 8) v = 64'h3F_FFFF_FFFF;
    else v = 64'h1C_0000_0000 + 64'($urandom_range(0, 4095));
    return v[37:0];
  endfunction

  task automatic traffic(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      s_awvalid = 1'($urandom); s_awaddr = pick(); m_awready = 1'($urandom);
      s_arvalid = 1'($urandom); s_araddr = pick(); m_arready = 1'($urandom);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_up();
  end

  initial begin
    rst_n = 0; apb_sel = 0; apb_enable = 0; apb_write = 0; apb_addr = '0; apb_wdata = '0;
    s_awvalid = 0; s_awaddr = '0; m_awready = 0; s_arvalid = 0; s_araddr = '0; m_arready = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    cmp_en = 1;

    // R12 R1: every word is zero after reset
    for (int i = 0; i < 8; i++) apb_rd("R12 R1 reset word", 4 * i, 32'h0, 32'h0);

    // R9 R7: kind 0 stalls before the enable, kind 1 does not
    @(posedge clk); #1;
    s_awvalid = 1; m_awready = 1; s_arvalid = 1; m_arready = 1; s_awaddr = 38'h00_1000_0000;
    @(negedge clk);
    chk("R9 blocked m_awvalid", {63'b0, m_awvalid_o[0]}, 64'h0);
    chk("R9 blocked s_arready", {63'b0, s_arready_o[0]}, 64'h0);
    chk("R7 kind1 open", {63'b0, m_awvalid_o[1]}, 64'h1);
    traffic(20);

    // R9 R8: enable set on kind 0, reserved on kind 1
    apb_wr(32'h1C, 32'h0000_0001);
    apb_rd("R9 R8 ctl word", 32'h1C, 32'h1, 32'h0);
    @(posedge clk); #1;
    s_awvalid = 1; m_awready = 1;
    @(negedge clk);
    chk("R9 open m_awvalid", {63'b0, m_awvalid_o[0]}, 64'h1);
    chk("R9 open s_awready", {63'b0, s_awready_o[0]}, 64'h1);
    apb_wr(32'h1C, 32'h0000_0000);
    apb_rd("R9 sticky enable", 32'h1C, 32'h1, 32'h0);

    // R3 R1 R8: offset -8 on word 0 with reserved bits set
    apb_wr(32'h00, 32'h7FFF_FFF8);
    apb_rd("R3 R1 R8 word0", 32'h00, 32'h0000_7FF8, 32'h0);
    addr_chk("R4 negative offset", 38'h00_8123_4567, 38'h00_7923_4567, 38'h00_8123_4567);

    apb_wr(32'h04, 32'h0000_0100);
    apb_wr(32'h08, 32'h0000_0040);
    apb_wr(32'h0C, 32'h0000_7000);
    apb_wr(32'h10, 32'h0000_0010);
    apb_wr(32'h14, 32'h0000_2800);
    apb_wr(32'h18, 32'h0000_0001);
    apb_rd("R1 R8 word5", 32'h14, 32'h0, 32'h0000_2800);

    addr_chk("R4 R5 high window 1", 38'h10_0000_0040, 38'h11_0000_0040, 38'h10_0000_0040);
    addr_chk("R4 carry dropped", 38'h18_0000_0ABC, 38'h18_0000_0ABC, 38'h00_0000_0ABC);
    addr_chk("R4 wrap negative", 38'h14_0000_0000, 38'h14_0000_0000, 38'h04_0000_0000);
    addr_chk("R5 trace window", 38'h00_E000_0000, 38'h00_E000_0000, 38'h00_E100_0000);
    addr_chk("R5 window 4 top", 38'h00_D0FF_FFFF, 38'h00_D0FF_FFFF, 38'h00_E0FF_FFFF);
    addr_chk("R6 past window 0", 38'h00_9000_0000, 38'h00_9000_0000, 38'h00_9000_0000);
    addr_chk("R6 past window 5", 38'h1C_0000_0000, 38'h1C_0000_0000, 38'h1C_0000_0000);
    addr_chk("R7 R8 window 2 per kind", 38'h00_C000_0000, 38'h00_C000_0000, 38'h01_0000_0000);

    traffic(400);

    // R11: write and transfer in the same cycle
    @(posedge clk); #1;
    s_araddr = 38'h00_C000_1000; s_arvalid = 1; m_arready = 1;
    apb_sel = 1; apb_enable = 0; apb_write = 1; apb_addr = 3'd2; apb_wdata = 32'h0000_0080;
    @(posedge clk); #1;
    apb_enable = 1;
    @(negedge clk);
    chk("R11 old offset in write cycle", {26'b0, m_araddr_o[1]}, {26'b0, 38'h01_0000_1000});
    @(posedge clk); #1;
    apb_sel = 0; apb_enable = 0; apb_write = 0;
    @(negedge clk);
    chk("R11 new offset next cycle", {26'b0, m_araddr_o[1]}, {26'b0, 38'h01_4000_1000});

    // R2: lock freezes a word
    apb_wr(32'h00, 32'h8000_0003);
    apb_rd("R2 locked write stored", 32'h00, 32'h8000_0003, 32'h0);
    apb_wr(32'h00, 32'h0000_0009);
    apb_rd("R2 write after lock ignored", 32'h00, 32'h8000_0003, 32'h0);
    addr_chk("R2 locked offset used", 38'h00_8000_0000, 38'h00_8300_0000, 38'h00_8000_0000);
    apb_wr(32'h1C, 32'h8000_0001);
    apb_rd("R2 ctl lock", 32'h1C, 32'h8000_0001, 32'h0);
    traffic(100);

    // R12 R2: reset clears locks, offsets and the enable
    @(posedge clk); #1;
    rst_n = 0; s_awvalid = 1; m_awready = 1;
    @(negedge clk);
    chk("R12 gate shut in reset", {63'b0, m_awvalid_o[0]}, 64'h0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    apb_rd("R12 word0 cleared", 32'h00, 32'h0, 32'h0);
    apb_rd("R12 ctl cleared", 32'h1C, 32'h0, 32'h0);
    apb_wr(32'h00, 32'h0000_0005);
    apb_rd("R2 lock gone after reset", 32'h00, 32'h0000_0005, 32'h0);
    traffic(50);

    finish_up();
  end
endmodule